// File: doc/BRIEF.md
# Paged Register Access Bridge

This block sits between a host that issues 16-bit logical register requests and a byte-oriented serial register bus whose target exposes a single 8-bit offset space banked by a page-select register. The upper byte of each logical address names the page and the lower byte names the offset within it. The bridge remembers which page it last selected on the target. Before an access, it inserts a page-select transaction only when the requested page is not the one it remembers.

The host side is a plain request/response port. A request carries an operation code, the logical address, write data or a bit mask, and a burst length. Responses arrive as one-cycle beats: one beat per byte read, or one beat that closes a write. The bus side is a byte-level port standing in for the serial wire protocol. Each byte is offered with start, stop and direction markers and held until the target reports it done, with or without an acknowledge.

Top module: `pgreg_bridge`

## Requirements
- R1: A page select is one write transaction of two bytes: the byte 0xFF with bus_start=1, then the page number with bus_stop=1.
- R2: After reset no page is remembered, so the first request issues a page select even when it targets page 0.
- R3: A request whose page equals the remembered page issues no page select.
- R4: The remembered page changes only when the page number byte completes with bus_nack=0. After a failed page select, the next request to that page selects it again.
- R5: Op 0 (byte read): a transaction that writes the offset (start and stop), then a read transaction of one byte. The response is one beat carrying the byte, with rsp_last=1 and rsp_err=0.
- R6: Op 1 (byte write): one transaction of offset then req_wdata[7:0], with stop on the data byte. The response is one beat with rsp_last=1 and rsp_err=0.
- R7: Op 2 (word write): one transaction of offset, req_wdata[15:8], req_wdata[7:0], with stop on the last byte only.
- R8: Op 3 (burst read): after the offset write, N consecutive bytes are read in one transaction, where N is req_len clamped to 1..128 (0 gives 1, above 128 gives 128). The response is N beats in offset order, with rsp_last=1 only on the N-th.
- R9: Op 4 (bit set) reads the byte, then writes back old OR req_wdata[7:0]. Op 5 (bit clear) writes back old AND NOT req_wdata[7:0]. Neither repeats the page select, and rsp_data carries the value written.
- R10: When a byte completes with bus_nack=1, the bridge issues a beat with rsp_err=1 and rsp_last=1 and offers no further byte for that request.
- R11: req_ready is high only while idle. It drops in the cycle after a request is accepted and is high again in the cycle of the final response beat.
- R12: Op codes 6 and 7 receive an immediate error beat with no bus activity.
- R13: An offered byte keeps bus_valid and all its markers and data stable until bus_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_op | input | 3 | Operation code (0..5 valid) |
| req_addr | input | 16 | Page in [15:8], offset in [7:0] |
| req_wdata | input | 16 | Write data, or mask in [7:0] |
| req_len | input | 8 | Burst length for op 3 |
| rsp_valid | output | 1 | Response beat |
| rsp_data | output | 8 | Read byte or byte written |
| rsp_err | output | 1 | Request failed on a bus byte or bad op |
| rsp_last | output | 1 | Final beat of the request |
| bus_valid | output | 1 | Byte offered to the bus |
| bus_start | output | 1 | Byte opens a transaction |
| bus_stop | output | 1 | Byte closes a transaction |
| bus_read | output | 1 | Byte is read from the target |
| bus_wdata | output | 8 | Byte to write |
| bus_done | input | 1 | Offered byte completed this cycle |
| bus_nack | input | 1 | Completed byte was not acknowledged |
| bus_rdata | input | 8 | Byte read from the target |

## Verification
The hardest situation to reach is a not-acknowledged page-number byte. It must leave the remembered page untouched, so that the retry selects the page again, and a port-level observer can see this only through the next request's byte count. The bench's target model refuses a chosen byte, counted from the request's first byte, and then reissues the same page. Random stalls on every byte and random pages drawn from a small set exercise both hits and misses of the remembered page.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam logic [2:0] OP_RD8   = 3'd0;
  localparam logic [2:0] OP_WR8   = 3'd1;
  localparam logic [2:0] OP_WR16  = 3'd2;
  localparam logic [2:0] OP_BURST = 3'd3;
  localparam logic [2:0] OP_SET   = 3'd4;
  localparam logic [2:0] OP_CLR   = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_PGO, S_PGD, S_OFS, S_RD, S_WHI, S_WLO
  } seq_state_t;
endpackage

// File: rtl/pgreg_page_cache.sv
module pgreg_page_cache #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [PAGE_W-1:0] req_page,
  output logic              hit
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      page_q  <= load_page;
    end
  end

  assign hit = valid_q && (page_q == req_page);
endmodule

// File: rtl/pgreg_modify.sv
module pgreg_modify #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] mask,
  input  logic              clear,
  output logic [DATA_W-1:0] new_val
);
  always_comb begin
    if (clear) new_val = old_val & ~mask;
    else       new_val = old_val | mask;
  end
endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
  import pgreg_pkg::*;
#(
  parameter int         MAX_BURST    = 128,
  parameter logic [7:0] PAGE_REG_OFS = 8'hFF,
  localparam int        LEN_W        = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_err,
  output logic             rsp_last,
  input  logic             cache_hit,
  output logic             cache_load,
  output logic [7:0]       cur_page,
  output logic [7:0]       mask,
  output logic             mod_clear,
  input  logic [7:0]       mod_new,
  output logic             bus_valid,
  output logic             bus_start,
  output logic             bus_stop,
  output logic             bus_read,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic             bus_nack,
  input  logic [7:0]       bus_rdata
);
  seq_state_t       st_q;
  logic [2:0]       op_q;
  logic [7:0]       ofs_q;
  logic [15:0]      data_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             wrph_q;
  logic             is_rmw, rd_phase, last_rd;

  function automatic logic [LEN_W-1:0] eff_len(input logic [2:0] op, input logic [LEN_W-1:0] n);
    if (op != OP_BURST || n == '0)   return LEN_W'(1);
    if (n > LEN_W'(MAX_BURST))       return LEN_W'(MAX_BURST);
    return n;
  endfunction

  assign is_rmw     = (op_q == OP_SET) || (op_q == OP_CLR);
  assign rd_phase   = (op_q == OP_RD8) || (op_q == OP_BURST) || (is_rmw && !wrph_q);
  assign last_rd    = (cnt_q == len_q - LEN_W'(1));
  assign req_ready  = (st_q == S_IDLE);
  assign cache_load = (st_q == S_PGD) && bus_done && !bus_nack;
  assign mask       = data_q[7:0];
  assign mod_clear  = (op_q == OP_CLR);

  always_comb begin
    bus_valid = (st_q != S_IDLE);
    bus_start = 1'b0;
    bus_stop  = 1'b0;
    bus_read  = 1'b0;
    bus_wdata = 8'h00;
    case (st_q)
      S_PGO: begin bus_wdata = PAGE_REG_OFS; bus_start = 1'b1; end
      S_PGD: begin bus_wdata = cur_page;     bus_stop  = 1'b1; end
      S_OFS: begin bus_wdata = ofs_q; bus_start = 1'b1; bus_stop = rd_phase; end
      S_RD:  begin bus_read = 1'b1; bus_start = (cnt_q == '0); bus_stop = last_rd; end
      S_WHI: bus_wdata = data_q[15:8];
      S_WLO: begin bus_wdata = data_q[7:0]; bus_stop = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      op_q      <= OP_RD8;
      cur_page  <= '0;
      ofs_q     <= '0;
      data_q    <= '0;
      len_q     <= LEN_W'(1);
      cnt_q     <= '0;
      wrph_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
      if (st_q == S_IDLE) begin
        if (req_valid) begin
          op_q     <= req_op;
          cur_page <= req_addr[15:8];
          ofs_q    <= req_addr[7:0];
          data_q   <= req_wdata;
          len_q    <= eff_len(req_op, req_len);
          cnt_q    <= '0;
          wrph_q   <= 1'b0;
          if (req_op > OP_CLR) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_last  <= 1'b1;
          end else begin
            st_q <= cache_hit ? S_OFS : S_PGO;
          end
        end
      end else if (bus_done) begin
        if (bus_nack) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_last  <= 1'b1;
          st_q      <= S_IDLE;
        end else begin
          case (st_q)
            S_PGO: st_q <= S_PGD;
            S_PGD: st_q <= S_OFS;
            S_OFS: begin
              cnt_q <= '0;
              if (rd_phase)               st_q <= S_RD;
              else if (op_q == OP_WR16)   st_q <= S_WHI;
              else                        st_q <= S_WLO;
            end
            S_RD: begin
              if (is_rmw) begin
                data_q[7:0] <= mod_new;
                wrph_q      <= 1'b1;
                st_q        <= S_OFS;
              end else begin
                rsp_valid <= 1'b1;
                rsp_data  <= bus_rdata;
                rsp_last  <= last_rd;
                cnt_q     <= cnt_q + LEN_W'(1);
                if (last_rd) st_q <= S_IDLE;
              end
            end
            S_WHI: st_q <= S_WLO;
            S_WLO: begin
              rsp_valid <= 1'b1;
              rsp_last  <= 1'b1;
              rsp_data  <= data_q[7:0];
              st_q      <= S_IDLE;
            end
            default: st_q <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pgreg_bridge.sv
module pgreg_bridge #(
  parameter int         MAX_BURST    = 128,
  parameter logic [7:0] PAGE_REG_OFS = 8'hFF,
  localparam int        LEN_W        = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_err,
  output logic             rsp_last,
  output logic             bus_valid,
  output logic             bus_start,
  output logic             bus_stop,
  output logic             bus_read,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic             bus_nack,
  input  logic [7:0]       bus_rdata
);
  logic       cache_hit, cache_load, mod_clear;
  logic [7:0] cur_page, mask, mod_new;

  pgreg_page_cache #(.PAGE_W(8)) u_cache (
    .clk(clk), .rst(rst), .load(cache_load), .load_page(cur_page),
    .req_page(req_addr[15:8]), .hit(cache_hit)
  );

  pgreg_modify #(.DATA_W(8)) u_mod (
    .old_val(bus_rdata), .mask(mask), .clear(mod_clear), .new_val(mod_new)
  );

  pgreg_seq #(.MAX_BURST(MAX_BURST), .PAGE_REG_OFS(PAGE_REG_OFS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last),
    .cache_hit(cache_hit), .cache_load(cache_load), .cur_page(cur_page),
    .mask(mask), .mod_clear(mod_clear), .mod_new(mod_new),
    .bus_valid(bus_valid), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_read(bus_read), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_nack(bus_nack), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/pgreg_bridge_chk.sv
module pgreg_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       rsp_last,
  input logic       bus_valid,
  input logic       bus_done,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       bus_read,
  input logic [7:0] bus_wdata
);
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_wdata) && $stable(bus_read)
                                  && $stable(bus_start) && $stable(bus_stop)));

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op <= 3'd5) |=> !req_ready);

  p_last_ready_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_last) |-> req_ready);

  p_mid_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_last) |-> !req_ready);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_last && !bus_valid));

  p_bad_op_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op > 3'd5) |=> (rsp_valid && rsp_err && !bus_valid));
endmodule

bind pgreg_bridge pgreg_bridge_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_last(rsp_last),
  .bus_valid(bus_valid), .bus_done(bus_done), .bus_start(bus_start),
  .bus_stop(bus_stop), .bus_read(bus_read), .bus_wdata(bus_wdata)
);

// File: tb/pgreg_bridge_bench.sv
`timescale 1ns/1ps
module pgreg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_len = '0;
  logic        rsp_valid, rsp_err, rsp_last;
  logic [7:0]  rsp_data;
  logic        bus_valid, bus_start, bus_stop, bus_read;
  logic [7:0]  bus_wdata;
  logic        bus_done = 1'b0;
  logic        bus_nack = 1'b0;
  logic [7:0]  bus_rdata = '0;

  always #10 clk = ~clk;

  pgreg_bridge u_pgreg_bridge (.*);

  // target model: 4 pages of 256 bytes, offset 0xFF selects the page
  logic [7:0] mem [0:1023];
  logic [7:0] tpage, ptr;
  int hs_cnt, pgsel_cnt;
  int nack_at = -1;
  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 37 + 5);
      tpage <= 8'h00; ptr <= 8'h00; hs_cnt <= 0; pgsel_cnt <= 0;
    end else if (bus_valid && bus_done) begin
      hs_cnt <= hs_cnt + 1;
      if (!bus_nack) begin
        if (bus_read) ptr <= ptr + 8'd1;
        else if (bus_start) ptr <= bus_wdata;
        else begin
          if (ptr == 8'hFF) begin tpage <= bus_wdata; pgsel_cnt <= pgsel_cnt + 1; end
          else mem[{tpage[1:0], ptr}] <= bus_wdata;
          ptr <= ptr + 8'd1;
        end
      end
    end
  end

  always @(negedge clk) begin
    bus_done  = bus_valid && ($urandom % 4 != 0);
    bus_rdata = mem[{tpage[1:0], ptr}];
    bus_nack  = bus_done && (hs_cnt == nack_at);
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_rmw(input logic [2:0] op, input logic [7:0] o, input logic [7:0] m);
    return (op == 3'd5) ? (o & ~m) : (o | m);
  endfunction

  function automatic int f_idx(input logic [15:0] a);
    return int'({a[9:8], a[7:0]});
  endfunction

  logic [7:0] rbuf [0:127];
  int  nbeats, hs_d, pg_d;
  bit  rerr, busy_seen;

  task automatic do_req(input logic [2:0] op, input logic [15:0] a, input logic [15:0] w, input logic [7:0] l);
    int hs0, pg0;
    hs0 = hs_cnt; pg0 = pgsel_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_wdata = w; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    nbeats = 0; rerr = 1'b0;
    forever begin
      if (rsp_valid) begin
        if (nbeats < 128) rbuf[nbeats] = rsp_data;
        nbeats++;
        if (rsp_err) rerr = 1'b1;
        if (rsp_last) break;
      end
      @(negedge clk);
    end
    hs_d = hs_cnt - hs0;
    pg_d = pgsel_cnt - pg0;
  endtask

  logic [7:0] old_v;
  logic       exp_pv = 1'b0;
  logic [7:0] exp_pg = '0;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset ready", int'(req_ready), 1);
    chk("R11 reset rsp_valid", int'(rsp_valid), 0);
    chk("R13 reset bus_valid", int'(bus_valid), 0);

    // first access, page 0
    do_req(3'd1, 16'h0010, 16'h005A, 8'd0);
    chk("R2 first page select", pg_d, 1);
    chk("R1 page select bytes", hs_d, 4);
    chk("R6 write mem", int'(mem[f_idx(16'h0010)]), 'h5A);
    chk("R6 single beat", nbeats, 1);
    chk("R6 no err", int'(rerr), 0);
    chk("R11 busy after accept", int'(busy_seen), 1);

    do_req(3'd0, 16'h0010, 16'h0, 8'd0);
    chk("R3 no page select", pg_d, 0);
    chk("R5 read bytes", hs_d, 2);
    chk("R5 read data", int'(rbuf[0]), 'h5A);

    do_req(3'd2, 16'h0220, 16'hBEEF, 8'd0);
    chk("R1 new page select", pg_d, 1);
    chk("R7 word bytes", hs_d, 5);
    chk("R7 msb", int'(mem[f_idx(16'h0220)]), 'hBE);
    chk("R7 lsb", int'(mem[f_idx(16'h0221)]), 'hEF);

    do_req(3'd4, 16'h0220, 16'h0041, 8'd0);
    chk("R9 set data", int'(rbuf[0]), 'hFF);
    chk("R9 set mem", int'(mem[f_idx(16'h0220)]), 'hFF);
    chk("R9 set bytes", hs_d, 4);
    do_req(3'd5, 16'h0220, 16'h000F, 8'd0);
    chk("R9 clear data", int'(rbuf[0]), 'hF0);
    chk("R9 clear mem", int'(mem[f_idx(16'h0220)]), 'hF0);

    do_req(3'd3, 16'h0200, 16'h0, 8'd0);
    chk("R8 len 0 beats", nbeats, 1);
    do_req(3'd3, 16'h0200, 16'h0, 8'd200);
    chk("R8 clamp beats", nbeats, 128);
    chk("R8 clamp bytes", hs_d, 129);
    begin
      int bad = 0;
      for (int i = 0; i < 128; i++)
        if (rbuf[i] != mem[f_idx(16'h0200) + i]) bad++;
      chk("R8 burst data", bad, 0);
    end

    // refuse the page number byte
    nack_at = hs_cnt + 1;
    do_req(3'd0, 16'h0305, 16'h0, 8'd0);
    nack_at = -1;
    chk("R4 nack err", int'(rerr), 1);
    chk("R10 stop after nack", hs_d, 2);
    chk("R4 page not taken", pg_d, 0);
    do_req(3'd0, 16'h0305, 16'h0, 8'd0);
    chk("R4 reselect", pg_d, 1);
    chk("R4 read data", int'(rbuf[0]), int'(mem[f_idx(16'h0305)]));

    old_v = mem[f_idx(16'h0330)];
    nack_at = hs_cnt;
    do_req(3'd2, 16'h0330, 16'h1234, 8'd0);
    nack_at = -1;
    chk("R10 offset nack err", int'(rerr), 1);
    chk("R10 offset nack bytes", hs_d, 1);
    chk("R10 mem untouched", int'(mem[f_idx(16'h0330)]), int'(old_v));

    nack_at = hs_cnt + 3;
    do_req(3'd3, 16'h0300, 16'h0, 8'd10);
    nack_at = -1;
    chk("R10 burst nack beats", nbeats, 3);
    chk("R10 burst nack bytes", hs_d, 4);

    do_req(3'd6, 16'h0300, 16'h0, 8'd0);
    chk("R12 bad op err", int'(rerr), 1);
    chk("R12 no bus bytes", hs_d, 0);

    exp_pv = 1'b1; exp_pg = 8'h03;
    for (int it = 0; it < 80; it++) begin
      logic [2:0]  op;
      logic [7:0]  pg, ofs, ln;
      logic [15:0] wd, a;
      int base, n;
      bit sel;
      op  = 3'($urandom % 6);
      pg  = 8'($urandom % 4);
      ofs = 8'($urandom % 8'hF0);
      ln  = 8'(1 + $urandom % 16);
      wd  = 16'($urandom);
      a   = {pg, ofs};
      sel = !(exp_pv && exp_pg == pg);
      old_v = mem[f_idx(a)];
      n = (op == 3'd3) ? int'(ln) : 1;
      case (op)
        3'd0, 3'd1: base = 2;
        3'd2:       base = 3;
        3'd3:       base = 1 + n;
        default:    base = 4;
      endcase
      do_req(op, a, wd, ln);
      exp_pv = 1'b1; exp_pg = pg;
      chk("R3 random page select", pg_d, sel ? 1 : 0);
      chk("R13 random byte count", hs_d, base + (sel ? 2 : 0));
      chk("R10 random no err", int'(rerr), 0);
      case (op)
        3'd0, 3'd3: begin
          int bad = 0;
          for (int i = 0; i < n; i++) if (rbuf[i] != mem[f_idx(a) + i]) bad++;
          chk("R8 random read data", bad, 0);
        end
        3'd1: chk("R6 random write", int'(mem[f_idx(a)]), int'(wd[7:0]));
        3'd2: chk("R7 random word", int'({mem[f_idx(a)], mem[f_idx(a) + 1]}), int'(wd));
        default: chk("R9 random rmw", int'(mem[f_idx(a)]), int'(f_rmw(op, old_v, wd[7:0])));
      endcase
    end

    summary();
    $finish;
  end
endmodule